// File: doc/BRIEF.md
# Exception Escalation and Shutdown Tracker

This block sits beside the exception sequencer of a processor core. It watches every exception reported while the core is still starting the handler of an earlier one. For each report it makes one of four choices. It can pass the new vector on unchanged, turn it into a double fault (vector 8), deliver the page-fault vector (14) once more, or stop the core in a shutdown state.

A page fault that arrives while the page-fault handler is being entered does not escalate. The page-fault handler is started again instead, and only a fault after that repeated entry shuts the core down. A fault during double-fault entry also shuts the core down. When handler entry finishes, the entry-complete strobe returns the tracker to idle.

Each decision appears on the outputs one clock after the report. The shutdown flag stays set until reset.

Top module: `exc_escalation_tracker`

## Requirements
- R1: After reset `dlv_valid` and `shutdown` are 0 and the tracker is idle.
- R2: A report received while idle, or within a window opened by a vector that is not 8, 10 to 13 or 14, is delivered unchanged: `dlv_valid`=1 and `dlv_vector` equals the reported vector on the cycle after the report.
- R3: While entering a segment-class handler (vectors 10, 11, 12, 13), a report of any vector other than 14 delivers vector 8.
- R4: While entering a segment-class handler, a report of vector 14 delivers vector 14 and opens a page-fault window.
- R5: While entering the page-fault handler for the first time, a report of any vector other than 14 delivers vector 8.
- R6: While entering the page-fault handler for the first time, a second report of vector 14 delivers vector 14 again.
- R7: Any report after that repeated page-fault delivery, before entry completes, sets `shutdown` one cycle later and delivers nothing.
- R8: Any report while entering the double-fault handler (opened by a delivered vector 8) sets `shutdown` and delivers nothing.
- R9: `entry_done` returns the tracker to idle. If `exc_valid` is also high in that cycle, the report is handled first and its window stays open.
- R10: Once set, `shutdown` stays 1 until reset. While it is set `dlv_valid` stays 0, and neither reports nor `entry_done` have any effect.
- R11: A report received inside a window opened by a vector outside 8, 10 to 14 is delivered unchanged, and the new vector's class sets the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception report strobe |
| exc_vector | input | 8 | Reported exception vector |
| entry_done | input | 1 | Handler entry completed |
| dlv_valid | output | 1 | Vector delivery strobe |
| dlv_vector | output | 8 | Vector to deliver |
| shutdown | output | 1 | Sticky shutdown flag |

## Verification
The bench drives chains of two or three reports separated by entry-complete strobes, and each chain opens a different window class. Segment class followed by a general fault, and segment class followed by a page fault, separate the double-fault rule from the page-fault exception to it. Page fault followed by page fault and then a third fault separates re-delivery from shutdown. Further chains show that a reported vector 8 arms shutdown and that a report and entry-complete in the same cycle keep the window. Reports and strobes sent after shutdown show that the flag stays set and that nothing is delivered.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;
  typedef enum logic [2:0] {
    TRK_IDLE, TRK_BENIGN, TRK_SEG, TRK_PF, TRK_PF_AGAIN, TRK_DF
  } trk_state_t;

  typedef enum logic [1:0] {
    CLS_OTHER, CLS_SEG, CLS_PF, CLS_DF
  } exc_class_t;

  // Map a vector onto its escalation class.
  function automatic exc_class_t classify(input int unsigned vec,
                                          input int unsigned pf_vec,
                                          input int unsigned df_vec,
                                          input int unsigned seg_lo,
                                          input int unsigned seg_hi);
    if (vec == pf_vec)                     return CLS_PF;
    else if (vec == df_vec)                return CLS_DF;
    else if (vec >= seg_lo && vec <= seg_hi) return CLS_SEG;
    else                                   return CLS_OTHER;
  endfunction

  // Window opened when a vector is delivered.
  function automatic trk_state_t window_of(input exc_class_t c);
    case (c)
      CLS_SEG: return TRK_SEG;
      CLS_PF:  return TRK_PF;
      CLS_DF:  return TRK_DF;
      default: return TRK_BENIGN;
    endcase
  endfunction
endpackage

// File: rtl/exc_classifier.sv
module exc_classifier
  import exc_esc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int PF_VEC = 14,
  parameter int DF_VEC = 8,
  parameter int SEG_LO = 10,
  parameter int SEG_HI = 13
) (
  input  logic [VEC_W-1:0] vec,
  output exc_class_t       cls
);
  always_comb begin
    cls = classify(int'(vec), PF_VEC, DF_VEC, SEG_LO, SEG_HI);
  end
endmodule

// File: rtl/exc_escalation_fsm.sv
module exc_escalation_fsm
  import exc_esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_valid,
  input  exc_class_t cls,
  input  logic       entry_done,
  input  logic       halted,
  output trk_state_t state,
  output logic       pass_thru,
  output logic       esc_df,
  output logic       redo_pf,
  output logic       go_shut
);
  trk_state_t state_nx;

  always_comb begin
    state_nx  = state;
    pass_thru = 1'b0;
    esc_df    = 1'b0;
    redo_pf   = 1'b0;
    go_shut   = 1'b0;
    if (!halted) begin
      if (exc_valid) begin
        case (state)
          TRK_IDLE, TRK_BENIGN: begin
            pass_thru = 1'b1;
            state_nx  = window_of(cls);
          end
          TRK_SEG: begin
            if (cls == CLS_PF) begin
              pass_thru = 1'b1;
              state_nx  = TRK_PF;
            end else begin
              esc_df   = 1'b1;
              state_nx = TRK_DF;
            end
          end
          TRK_PF: begin
            if (cls == CLS_PF) begin
              redo_pf  = 1'b1;
              state_nx = TRK_PF_AGAIN;
            end else begin
              esc_df   = 1'b1;
              state_nx = TRK_DF;
            end
          end
          default: begin
            go_shut  = 1'b1;
            state_nx = TRK_IDLE;
          end
        endcase
      end else if (entry_done) begin
        state_nx = TRK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= TRK_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/exc_delivery_reg.sv
module exc_delivery_reg #(
  parameter int VEC_W  = 8,
  parameter int PF_VEC = 14,
  parameter int DF_VEC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] exc_vector,
  input  logic             pass_thru,
  input  logic             esc_df,
  input  logic             redo_pf,
  input  logic             go_shut,
  output logic             dlv_valid,
  output logic [VEC_W-1:0] dlv_vector,
  output logic             shutdown
);
  localparam logic [VEC_W-1:0] PF_CODE = VEC_W'(PF_VEC);
  localparam logic [VEC_W-1:0] DF_CODE = VEC_W'(DF_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_valid  <= 1'b0;
      dlv_vector <= '0;
      shutdown   <= 1'b0;
    end else begin
      dlv_valid <= pass_thru | esc_df | redo_pf;
      if (pass_thru)    dlv_vector <= exc_vector;
      else if (esc_df)  dlv_vector <= DF_CODE;
      else if (redo_pf) dlv_vector <= PF_CODE;
      if (go_shut) shutdown <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_escalation_tracker.sv
module exc_escalation_tracker
  import exc_esc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int PF_VEC = 14,
  parameter int DF_VEC = 8,
  parameter int SEG_LO = 10,
  parameter int SEG_HI = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic [VEC_W-1:0] exc_vector,
  input  logic             entry_done,
  output logic             dlv_valid,
  output logic [VEC_W-1:0] dlv_vector,
  output logic             shutdown
);
  exc_class_t cls;
  trk_state_t state;
  logic pass_thru, esc_df, redo_pf, go_shut;

  exc_classifier #(.VEC_W(VEC_W), .PF_VEC(PF_VEC), .DF_VEC(DF_VEC),
                   .SEG_LO(SEG_LO), .SEG_HI(SEG_HI)) u_cls (
    .vec(exc_vector), .cls(cls));

  exc_escalation_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .cls(cls),
    .entry_done(entry_done), .halted(shutdown), .state(state),
    .pass_thru(pass_thru), .esc_df(esc_df), .redo_pf(redo_pf),
    .go_shut(go_shut));

  exc_delivery_reg #(.VEC_W(VEC_W), .PF_VEC(PF_VEC), .DF_VEC(DF_VEC)) u_dlv (
    .clk(clk), .rst_n(rst_n), .exc_vector(exc_vector),
    .pass_thru(pass_thru), .esc_df(esc_df), .redo_pf(redo_pf),
    .go_shut(go_shut), .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
    .shutdown(shutdown));
endmodule

// File: rtl/exc_escalation_chk.sv
module exc_escalation_chk #(
  parameter int VEC_W  = 8,
  parameter int PF_VEC = 14,
  parameter int DF_VEC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_valid,
  input logic [VEC_W-1:0] exc_vector,
  input logic             dlv_valid,
  input logic [VEC_W-1:0] dlv_vector,
  input logic             shutdown,
  input logic             pass_thru,
  input logic             esc_df,
  input logic             redo_pf,
  input logic             go_shut
);
  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |=> dlv_valid && dlv_vector == $past(exc_vector)); // R2
  AST_DLV_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $past(exc_valid)); // R2
  AST_ESCALATE_DF: assert property (@(posedge clk) disable iff (!rst_n)
    esc_df |=> dlv_valid && dlv_vector == VEC_W'(DF_VEC)); // R3
  AST_PF_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
    redo_pf |=> dlv_valid && dlv_vector == VEC_W'(PF_VEC)); // R6
  AST_SHUT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    go_shut |=> shutdown && !dlv_valid); // R7
  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown); // R10
  AST_SHUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !dlv_valid); // R10
endmodule

bind exc_escalation_tracker exc_escalation_chk #(
  .VEC_W(VEC_W), .PF_VEC(PF_VEC), .DF_VEC(DF_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_vector(exc_vector),
  .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .shutdown(shutdown),
  .pass_thru(pass_thru), .esc_df(esc_df), .redo_pf(redo_pf),
  .go_shut(go_shut));

// File: tb/exc_escalation_tracker_test.sv
module exc_escalation_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid = 1'b0;
  logic [7:0] exc_vector = 8'd0;
  logic entry_done = 1'b0;
  logic dlv_valid;
  logic [7:0] dlv_vector;
  logic shutdown;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Reference model: window kind as an integer
  // 0 idle, 1 plain, 2 segment, 3 page fault, 4 page fault repeated, 5 double fault
  int m_win = 0;
  bit m_dv = 0;
  int m_vec = 0;
  bit m_sd = 0;

  always #2.5 clk = ~clk;

  exc_escalation_tracker uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_vector(exc_vector),
    .entry_done(entry_done), .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
    .shutdown(shutdown));

  function automatic int kind_of(int v);
    if (v == 14) return 3;
    if (v == 8) return 5;
    if (v inside {10, 11, 12, 13}) return 2;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_dv = 0; m_sd = 0; m_vec = 0;
    end else begin
      m_dv = 0;
      if (!m_sd && exc_valid) begin
        int v;
        v = int'(exc_vector);
        if (m_win <= 1) begin
          m_dv = 1; m_vec = v; m_win = kind_of(v);
        end else if (m_win == 2 || m_win == 3) begin
          if (v == 14) begin
            m_dv = 1; m_vec = 14; m_win = (m_win == 2) ? 3 : 4;
          end else begin
            m_dv = 1; m_vec = 8; m_win = 5;
          end
        end else begin
          m_sd = 1; m_win = 0;
        end
      end else if (!m_sd && entry_done) begin
        m_win = 0;
      end
    end
  end

  task automatic check(string req, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, dlv_valid == m_dv, "dlv_valid", dlv_valid, m_dv);
      if (m_dv) check(cur_req, int'(dlv_vector) == m_vec, "dlv_vector", dlv_vector, m_vec);
      check(cur_req, shutdown == m_sd, "shutdown", shutdown, m_sd);
    end
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 5000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic report(int v, string req);
    @(negedge clk);
    cur_req = req;
    exc_valid = 1'b1; exc_vector = 8'(v);
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  task automatic done_pulse(string req);
    @(negedge clk);
    cur_req = req;
    entry_done = 1'b1;
    @(negedge clk);
    entry_done = 1'b0;
  endtask

  task automatic expect_out(string req, bit dv, int vec, bit sd);
    // called right after a report task: the outputs now show its decision
    check(req, dlv_valid == dv, "explicit dlv_valid", dlv_valid, dv);
    if (dv) check(req, int'(dlv_vector) == vec, "explicit dlv_vector", dlv_vector, vec);
    check(req, shutdown == sd, "explicit shutdown", shutdown, sd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", !dlv_valid && !shutdown, "reset outputs", {dlv_valid, shutdown}, 0);

    report(3, "R2");          expect_out("R2", 1, 3, 0);
    report(40, "R11");        expect_out("R11", 1, 40, 0);
    done_pulse("R9");

    report(13, "R3");         expect_out("R2", 1, 13, 0);
    report(0, "R3");          expect_out("R3", 1, 8, 0);
    done_pulse("R9");
    report(5, "R9");          expect_out("R9", 1, 5, 0);
    done_pulse("R9");

    report(11, "R4");
    report(14, "R4");         expect_out("R4", 1, 14, 0);
    report(14, "R6");         expect_out("R6", 1, 14, 0);
    report(5, "R7");          expect_out("R7", 0, 0, 1);
    report(14, "R10");        expect_out("R10", 0, 0, 1);
    done_pulse("R10");
    report(3, "R10");         expect_out("R10", 0, 0, 1);
    repeat (3) @(negedge clk);
    check("R10", shutdown == 1'b1, "held shutdown", shutdown, 1);

    do_reset();
    @(negedge clk);
    check("R1", !dlv_valid && !shutdown, "reset clears shutdown", shutdown, 0);
    report(14, "R5");         expect_out("R2", 1, 14, 0);
    report(6, "R5");          expect_out("R5", 1, 8, 0);
    report(0, "R8");          expect_out("R8", 0, 0, 1);

    do_reset();
    report(8, "R8");          expect_out("R8", 1, 8, 0);
    report(3, "R8");          expect_out("R8", 0, 0, 1);

    do_reset();
    report(1, "R11");
    report(2, "R11");         expect_out("R11", 1, 2, 0);
    // report and entry_done together: report wins, segment window remains
    @(negedge clk);
    cur_req = "R9";
    exc_valid = 1'b1; exc_vector = 8'd12; entry_done = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0; entry_done = 1'b0;
    expect_out("R9", 1, 12, 0);
    report(7, "R9");          expect_out("R9", 1, 8, 0);
    done_pulse("R9");
    report(9, "R9");          expect_out("R9", 1, 9, 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule